// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register Interface

This block is the digital front end of a four-channel converter. Each channel keeps two code registers in series. A staging register is filled from a shared parallel bus. A second register sits behind it and alone sets the code that channel presents at its output.

An active-low write strobe, steered by a two-bit channel address, fills one staging register. An active-low load strobe is common to all channels and copies every staging register into its output register together. Software can therefore prepare all four channels one at a time and then update them in a single step.

Both stages are transparent while their strobe is low and hold once it returns high. Transparency is modelled synchronously: the strobes, the address and the bus are sampled on each rising clock edge, and an open register reloads on every sampled cycle. The two strobes act independently of each other. When they overlap, the load strobe has to stay low for a minimum number of cycles after write releases. The block raises a one-cycle flag when that hold is cut short.

Top module: `quad_dac_regs`

## Requirements
- R1: While synchronous reset is high, every staging register and every output code clears to zero and `hold_err` is low from the next edge on.
- R2: Address decoding is 0 for channel A, 1 for B, 2 for C and 3 for D. A staging register whose address is not selected, or whose write strobe is high, keeps its value.
- R3: In every sampled cycle with `wr_n` low, the addressed staging register loads `din`. A change of address while write stays low moves loading to the newly addressed channel. After `wr_n` rises, the register holds the last value it loaded.
- R4: With `ld_n` high, all four output codes hold, whatever happens on write, address or data.
- R5: In every sampled cycle with `ld_n` low, each channel's output code loads that channel's staging register. After `ld_n` rises, all four codes hold together.
- R6: With both strobes low, the selected channel's output code equals the sampled `din` one clock later.
- R7: With both strobes high, no staging register and no output code changes.
- R8: An overlapped write release is a sample where `wr_n` rises while `ld_n` was low in the previous sample. If `ld_n` then rises m samples later with m < `HOLD_CYC` (m = 0 meaning the same sample), `hold_err` is high for the one clock that follows. If m >= `HOLD_CYC`, no flag is raised.
- R9: `hold_err` is only ever high for a single cycle, and only directly after a sampled rising edge of `ld_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe for the addressed staging register |
| ld_n | input | 1 | Active-low load strobe shared by all four output registers |
| addr | input | 2 | Channel select for writes (0=A, 1=B, 2=C, 3=D) |
| din | input | DATA_W | Shared parallel data bus |
| code_a | output | DATA_W | Output code of channel A |
| code_b | output | DATA_W | Output code of channel B |
| code_c | output | DATA_W | Output code of channel C |
| code_d | output | DATA_W | Output code of channel D |
| hold_err | output | 1 | One-cycle pulse when the load strobe releases too soon after an overlapped write |

## Verification
The stimulus stages different values into channels with load held high. It then loads them all at once, so a swapped address decode or a load that touches only one channel shows up as a wrong code on a specific output. Several patterns are run against each other:
- an address change with write held low, which separates sampled-address steering from steering that latches the first address;
- both strobes low, which separates the fall-through path to the output from the plain one-cycle pipeline;
- write pulses with load high, which show that the outputs are isolated from the staging side.

The hold monitor is driven with load releases at 0, 1, 2 and exactly `HOLD_CYC` samples after an overlapped write release. This places the flag boundary at m < `HOLD_CYC` and rules out an off-by-one in the counter.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = $clog2(NUM_CH);

    typedef logic [ADDR_W-1:0] ch_addr_t;

endpackage

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              ld_act,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] stage_val,
    output logic [DATA_W-1:0] code_val
);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] code;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            st_d.stage = din;
        end
        if (ld_act) begin
            st_d.code = st_d.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_val = st_q.stage;
    assign code_val  = st_q.code;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (stage_val == '0 && code_val == '0));

    assert_write_load_R3: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> stage_val == $past(din));

    assert_load_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (ld_act && !wr_sel) |=> code_val == $past(stage_val));

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ld_act |=> $stable(code_val));

    assert_fall_through_R6: assert property (@(posedge clk) disable iff (rst)
        (ld_act && wr_sel) |=> code_val == $past(din));

endmodule

// File: rtl/dac_hold_mon.sv
module dac_hold_mon #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    input  logic ld_n,
    output logic hold_err
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic             wr_prev;
        logic             ld_prev;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             viol;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       wr_rise, ld_rise, overlap;

    always_comb begin
        wr_rise = !st_q.wr_prev && wr_n;
        ld_rise = !st_q.ld_prev && ld_n;
        overlap = wr_rise && !st_q.ld_prev;

        st_d         = st_q;
        st_d.wr_prev = wr_n;
        st_d.ld_prev = ld_n;
        st_d.viol    = 1'b0;

        if (overlap) begin
            if (ld_rise) begin
                st_d.viol  = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
                st_d.cnt   = CNT_W'(1);
            end
        end else if (st_q.armed) begin
            if (ld_rise) begin
                st_d.viol  = (st_q.cnt < CNT_LIM);
                st_d.armed = 1'b0;
            end else if (st_q.cnt >= CNT_LIM) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.wr_prev <= 1'b1;
            st_q.ld_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_err = st_q.viol;

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        hold_err |=> !hold_err);

    assert_err_after_ld_rise_R9: assert property (@(posedge clk) disable iff (rst)
        hold_err |-> ($past(ld_n) && !$past(ld_n, 2)));

    assert_same_edge_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_n) && wr_n && !$past(ld_n) && ld_n) |=> hold_err);

endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import quad_dac_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [DATA_W-1:0] code_c,
    output logic [DATA_W-1:0] code_d,
    output logic              hold_err
);

    logic [NUM_CH-1:0] wr_sel;
    logic [DATA_W-1:0] stage_vals [NUM_CH];
    logic [DATA_W-1:0] code_vals  [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        assign wr_sel[ch] = !wr_n && (ch_addr_t'(addr) == ch_addr_t'(ch));

        dac_chan_regs #(
            .DATA_W (DATA_W)
        ) chan_i (
            .clk       (clk),
            .rst       (rst),
            .wr_sel    (wr_sel[ch]),
            .ld_act    (!ld_n),
            .din       (din),
            .stage_val (stage_vals[ch]),
            .code_val  (code_vals[ch])
        );

        assert_unselected_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_n || ch_addr_t'(addr) != ch_addr_t'(ch)) |=> $stable(stage_vals[ch]));

        assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_n && ld_n) |=> ($stable(stage_vals[ch]) && $stable(code_vals[ch])));
    end

    dac_hold_mon #(
        .HOLD_CYC (HOLD_CYC)
    ) hold_mon_i (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .hold_err (hold_err)
    );

    assign code_a = code_vals[0];
    assign code_b = code_vals[1];
    assign code_c = code_vals[2];
    assign code_d = code_vals[3];

    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

endmodule

// File: tb/quad_dac_regs_tb_top.sv
module quad_dac_regs_tb_top;

    localparam int DATA_W   = 8;
    localparam int HOLD_CYC = 3;
    localparam int NVEC     = 27;

    // {wr_n, ld_n, addr, din, exp_a, exp_b, exp_c, exp_d, exp_err}
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 2'd0, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 0 R7 idle
        {1'b0, 1'b1, 2'd0, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 1 R4 stage A
        {1'b1, 1'b1, 2'd1, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 2 R7
        {1'b0, 1'b1, 2'd1, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 3 stage B
        {1'b0, 1'b1, 2'd2, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 4 R3 addr move -> C
        {1'b1, 1'b1, 2'd3, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // 5
        {1'b1, 1'b0, 2'd3, 8'h44, 8'h11, 8'h22, 8'h33, 8'h00, 1'b0}, // 6 R5 R2 load all
        {1'b1, 1'b1, 2'd3, 8'h44, 8'h11, 8'h22, 8'h33, 8'h00, 1'b0}, // 7 R9 ld rise, no arm
        {1'b0, 1'b1, 2'd3, 8'h55, 8'h11, 8'h22, 8'h33, 8'h00, 1'b0}, // 8 R4 stage D
        {1'b1, 1'b1, 2'd3, 8'h66, 8'h11, 8'h22, 8'h33, 8'h00, 1'b0}, // 9 R3 hold D
        {1'b0, 1'b0, 2'd0, 8'h77, 8'h77, 8'h22, 8'h33, 8'h55, 1'b0}, // 10 R6 fall-through
        {1'b0, 1'b0, 2'd0, 8'h78, 8'h78, 8'h22, 8'h33, 8'h55, 1'b0}, // 11 R6
        {1'b1, 1'b0, 2'd0, 8'h99, 8'h78, 8'h22, 8'h33, 8'h55, 1'b0}, // 12 overlapped release
        {1'b1, 1'b1, 2'd0, 8'h99, 8'h78, 8'h22, 8'h33, 8'h55, 1'b1}, // 13 R8 m=1
        {1'b1, 1'b1, 2'd0, 8'h99, 8'h78, 8'h22, 8'h33, 8'h55, 1'b0}, // 14 R9 pulse ends
        {1'b0, 1'b0, 2'd1, 8'h5A, 8'h78, 8'h5A, 8'h33, 8'h55, 1'b0}, // 15
        {1'b1, 1'b0, 2'd1, 8'h00, 8'h78, 8'h5A, 8'h33, 8'h55, 1'b0}, // 16 arm
        {1'b1, 1'b0, 2'd1, 8'h00, 8'h78, 8'h5A, 8'h33, 8'h55, 1'b0}, // 17
        {1'b1, 1'b0, 2'd1, 8'h00, 8'h78, 8'h5A, 8'h33, 8'h55, 1'b0}, // 18
        {1'b1, 1'b1, 2'd1, 8'h00, 8'h78, 8'h5A, 8'h33, 8'h55, 1'b0}, // 19 R8 m=HOLD ok
        {1'b0, 1'b0, 2'd2, 8'hC3, 8'h78, 8'h5A, 8'hC3, 8'h55, 1'b0}, // 20
        {1'b1, 1'b0, 2'd2, 8'h00, 8'h78, 8'h5A, 8'hC3, 8'h55, 1'b0}, // 21 arm
        {1'b1, 1'b0, 2'd2, 8'h00, 8'h78, 8'h5A, 8'hC3, 8'h55, 1'b0}, // 22
        {1'b1, 1'b1, 2'd2, 8'h00, 8'h78, 8'h5A, 8'hC3, 8'h55, 1'b1}, // 23 R8 m=2
        {1'b1, 1'b1, 2'd2, 8'h00, 8'h78, 8'h5A, 8'hC3, 8'h55, 1'b0}, // 24
        {1'b0, 1'b0, 2'd3, 8'h0F, 8'h78, 8'h5A, 8'hC3, 8'h0F, 1'b0}, // 25
        {1'b1, 1'b1, 2'd3, 8'h0F, 8'h78, 8'h5A, 8'hC3, 8'h0F, 1'b1}  // 26 R8 m=0
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_n, ld_n;
    logic [1:0]        addr;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] code_a, code_b, code_c, code_d;
    logic              hold_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    quad_dac_regs #(
        .DATA_W   (DATA_W),
        .HOLD_CYC (HOLD_CYC)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .addr     (addr),
        .din      (din),
        .code_a   (code_a),
        .code_b   (code_b),
        .code_c   (code_c),
        .code_d   (code_d),
        .hold_err (hold_err)
    );

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic l, input logic [1:0] a, input logic [7:0] d);
        wr_n = w; ld_n = l; addr = a; din = d;
        @(negedge clk);
    endtask

    function automatic logic [32:0] outs();
        return {code_a, code_b, code_c, code_d, hold_err};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_n = 1'b1; ld_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", outs(), 33'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][44], VEC[i][43], VEC[i][42:41], VEC[i][40:33]);
            check($sformatf("R2-R9 vector %0d", i), outs(), VEC[i][32:0]);
        end

        // R1: reset mid-run clears everything, including staging registers
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears codes", outs(), 33'h0);
        rst = 1'b0;
        drive(1'b1, 1'b0, 2'd0, 8'hEE);
        check("R1 staging cleared (load shows zero)", outs(), 33'h0);
        drive(1'b1, 1'b1, 2'd0, 8'hEE);

        // R4: writes with load high never reach outputs
        drive(1'b0, 1'b1, 2'd2, 8'hA5);
        drive(1'b0, 1'b1, 2'd2, 8'hB6);
        check("R4 code holds with load high", outs(), 33'h0);
        // R3 R5: last written value is what a later load sees
        drive(1'b1, 1'b1, 2'd2, 8'hFF);
        drive(1'b1, 1'b0, 2'd0, 8'hFF);
        check("R3 R5 last written value loaded", outs(), {8'h00, 8'h00, 8'hB6, 8'h00, 1'b0});
        // R8: overlap release held long enough, then load stays low forever -> no flag
        drive(1'b0, 1'b0, 2'd1, 8'h3C);
        drive(1'b1, 1'b0, 2'd1, 8'h3C);
        repeat (HOLD_CYC + 2) drive(1'b1, 1'b0, 2'd1, 8'h3C);
        check("R8 load kept low no flag", outs(), {8'h00, 8'h3C, 8'hB6, 8'h00, 1'b0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule